// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

The block gathers up to 32 interrupt request lines into a single interrupt output. Each line feeds a status bit that is latched either on a rising edge or on a high level; which of the two applies is fixed per line at build time by a mask parameter. Software reaches the block through a simple 32-bit register bus. It can write an enable mask directly or change single bits through set-only and clear-only ports. It clears latched requests with write-one-to-clear acknowledge writes, reads which enabled requests are pending, and reads a vector register that names the lowest-numbered pending line.

A two-bit master control register gates the block. One bit allows hardware requests to latch into status at all. The other lets pending requests drive the interrupt output. Register reads are combinational from the word address, so a read value is valid in the same cycle the address is presented. Writes take effect at the next rising clock edge.

Top module: `irqc_top`

## Requirements
- R1: Registers are selected by a 3-bit word address: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control. Acknowledge, set-enable and clear-enable read as zero.
- R2: Master control bit 0 (master enable) and bit 1 (hardware latch enable) read back as written. All other bits read as zero.
- R3: A write to set-enable sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: A write to clear-enable clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R5: A write to the enable register loads it directly. Bits at and above the number of inputs read as zero.
- R6: A write to acknowledge clears each status bit whose data bit is 1. Writes to status, pending and vector have no effect.
- R7: An edge-kind input (mask bit 1) sets its status bit on a rising edge only. A line held high does not set the bit again after an acknowledge.
- R8: A level-kind input (mask bit 0) sets its status bit on every cycle its line is high, so an acknowledge while the line stays high leaves the bit set.
- R9: While master control bit 1 is 0, no status bit becomes set.
- R10: Pending reads as status AND enable.
- R11: Vector reads the index of the lowest-numbered pending input, or 0xFFFFFFFF when nothing is pending.
- R12: The interrupt output is high exactly when master control bit 0 is 1 and at least one pending bit is 1.
- R13: When an acknowledge and a new input event hit the same status bit in the same cycle, the bit ends up set.
- R14: After reset, status, enable and master control are zero, vector reads 0xFFFFFFFF and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NUM_SRC | Interrupt request lines |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 3 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | 1 | Combined interrupt output |

## Verification
On every cycle, the assertions check the following. Set-enable and clear-enable writes land on the addressed bits. Acknowledges clear status when latching is off. No status bit rises while the hardware latch enable is low. The vector encoder always names the lowest pending bit, or reports none when nothing is pending. The interrupt output agrees with the master enable and the pending set. Other behaviour can only be shown by the bench's scenarios: the edge and level kinds, including re-latching of a held level line after an acknowledge; the priority of a new event over a same-cycle acknowledge; read-only registers ignoring writes; and the full sweeps of enable values against the vector and pending readback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Word-address map of the register bus
  typedef enum logic [2:0] {
    RS_STAT = 3'd0,
    RS_PEND = 3'd1,
    RS_ENA  = 3'd2,
    RS_ACK  = 3'd3,
    RS_SETE = 3'd4,
    RS_CLRE = 3'd5,
    RS_VEC  = 3'd6,
    RS_MCTL = 3'd7
  } reg_sel_e;

  localparam int BUS_W    = 32;
  localparam int MCTL_ME  = 0;  // drives the output
  localparam int MCTL_HIE = 1;  // lets requests latch

  localparam logic [BUS_W-1:0] VEC_NONE = {BUS_W{1'b1}};

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/irqc_src_cell.sv
module irqc_src_cell #(
  parameter bit EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic latch_en_i,
  input  logic ack_i,
  output logic stat_o
);
  logic evt;
  logic stat_q, stat_d;

  generate
    if (EDGE) begin : g_edge
      logic line_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_i;
      end
      assign evt = line_i & ~line_q;
    end else begin : g_level
      assign evt = line_i;
    end
  endgenerate

  // a fresh event outranks a same-cycle acknowledge
  always_comb begin
    stat_d = stat_q;
    if (ack_i)             stat_d = 1'b0;
    if (evt && latch_en_i) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irqc_lowest_idx.sv
module irqc_lowest_idx #(
  parameter int N     = 32,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = i[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int               NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = {NUM_SRC{1'b0}}
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               bus_wr_i,
  input  logic [2:0]         bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  output logic [31:0]        bus_rdata_o,
  output logic               irq_o
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               rst_sn;
  reg_sel_e           reg_sel;
  logic [NUM_SRC-1:0] wd_lo;
  logic [NUM_SRC-1:0] ena_q, ena_d;
  logic               ena_ce;
  logic [1:0]         mctl_q, mctl_d;
  logic               mctl_ce;
  logic [NUM_SRC-1:0] ack_vec;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] pend;
  logic               vec_found;
  logic [IDX_W-1:0]   vec_idx;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sn)
  );

  assign reg_sel = reg_sel_e'(bus_addr_i);
  assign wd_lo   = bus_wdata_i[NUM_SRC-1:0];
  assign ack_vec = (bus_wr_i && reg_sel == RS_ACK) ? wd_lo : '0;

  // one latch cell per request line
  generate
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      irqc_src_cell #(.EDGE(EDGE_MASK[g])) u_cell (
        .clk        (clk),
        .rst_n      (rst_sn),
        .line_i     (src_i[g]),
        .latch_en_i (mctl_q[MCTL_HIE]),
        .ack_i      (ack_vec[g]),
        .stat_o     (stat[g])
      );
    end
  endgenerate

  // enable mask: next state
  always_comb begin
    ena_ce = 1'b0;
    ena_d  = ena_q;
    if (bus_wr_i) begin
      case (reg_sel)
        RS_ENA:  begin ena_ce = 1'b1; ena_d = wd_lo;          end
        RS_SETE: begin ena_ce = 1'b1; ena_d = ena_q | wd_lo;  end
        RS_CLRE: begin ena_ce = 1'b1; ena_d = ena_q & ~wd_lo; end
        default: ;
      endcase
    end
  end

  // master control: next state
  always_comb begin
    mctl_ce = bus_wr_i && (reg_sel == RS_MCTL);
    mctl_d  = bus_wdata_i[1:0];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ena_q  <= '0;
      mctl_q <= '0;
    end else begin
      if (ena_ce)  ena_q  <= ena_d;
      if (mctl_ce) mctl_q <= mctl_d;
    end
  end

  assign pend = stat & ena_q;

  irqc_lowest_idx #(.N(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .vec_i   (pend),
    .found_o (vec_found),
    .idx_o   (vec_idx)
  );

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    case (reg_sel)
      RS_STAT: bus_rdata_o[NUM_SRC-1:0] = stat;
      RS_PEND: bus_rdata_o[NUM_SRC-1:0] = pend;
      RS_ENA:  bus_rdata_o[NUM_SRC-1:0] = ena_q;
      RS_VEC: begin
        if (vec_found) bus_rdata_o[IDX_W-1:0] = vec_idx;
        else           bus_rdata_o = VEC_NONE;
      end
      RS_MCTL: bus_rdata_o[1:0] = mctl_q;
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = mctl_q[MCTL_ME] & (|pend);

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input logic               clk,
  input logic               rst_sn,
  input logic               bus_wr_i,
  input logic [2:0]         bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic               irq_o,
  input logic [NUM_SRC-1:0] ena_q,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] pend,
  input logic [1:0]         mctl_q,
  input logic               vec_found,
  input logic [IDX_W-1:0]   vec_idx
);
  logic [NUM_SRC-1:0] wd;
  logic [NUM_SRC-1:0] below;
  logic               wr_ack, wr_set, wr_clr;

  assign wd     = bus_wdata_i[NUM_SRC-1:0];
  assign wr_ack = bus_wr_i && (bus_addr_i == RS_ACK);
  assign wr_set = bus_wr_i && (bus_addr_i == RS_SETE);
  assign wr_clr = bus_wr_i && (bus_addr_i == RS_CLRE);

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) below[i] = (i < int'(vec_idx));
  end

  AST_SET_EN_BITS: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_set |=> ((ena_q & $past(wd)) == $past(wd))); // R3
  AST_SET_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_set |=> ((ena_q & ~$past(wd)) == ($past(ena_q) & ~$past(wd)))); // R3
  AST_CLR_EN_BITS: assert property (@(posedge clk) disable iff (!rst_sn)
    wr_clr |=> ((ena_q & $past(wd)) == '0)); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    (wr_ack && !mctl_q[MCTL_HIE]) |=> ((stat & $past(wd)) == '0)); // R6
  AST_NO_LATCH_OFF: assert property (@(posedge clk) disable iff (!rst_sn)
    !mctl_q[MCTL_HIE] |=> ((stat & ~$past(stat)) == '0)); // R9
  AST_VEC_NONE: assert property (@(posedge clk) disable iff (!rst_sn)
    !vec_found |-> (pend == '0)); // R11
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_sn)
    vec_found |-> (pend[vec_idx] && ((pend & below) == '0))); // R11
  AST_IRQ_NEEDS_ME: assert property (@(posedge clk) disable iff (!rst_sn)
    irq_o |-> mctl_q[MCTL_ME]); // R12
  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_sn)
    (mctl_q[MCTL_ME] && (pend != '0)) |-> irq_o); // R12

endmodule

bind irqc_top irqc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_sn      (rst_sn),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .ena_q       (ena_q),
  .stat        (stat),
  .pend        (pend),
  .mctl_q      (mctl_q),
  .vec_found   (vec_found),
  .vec_idx     (vec_idx)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  localparam int N = 8;
  localparam logic [N-1:0] EMASK = 8'hF0;  // inputs 4..7 edge, 0..3 level

  localparam logic [2:0] A_STAT = 3'd0, A_PEND = 3'd1, A_ENA = 3'd2, A_ACK = 3'd3,
                         A_SETE = 3'd4, A_CLRE = 3'd5, A_VEC = 3'd6, A_MCTL = 3'd7;

  logic        clk;
  logic        rst_n;
  logic [N-1:0] src;
  logic        wr;
  logic [2:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  irqc_top #(.NUM_SRC(N), .EDGE_MASK(EMASK)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic drive_src(logic [N-1:0] v);
    @(negedge clk);
    src = v;
    @(negedge clk);
  endtask

  function automatic logic [31:0] lowest(logic [N-1:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; src = '0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R14 / R1: reset values over the whole map
    for (int a = 0; a < 8; a++) begin
      bus_read(3'(a), v);
      chk("R14", v, (a == 6) ? 32'hFFFF_FFFF : 32'h0);
    end
    chk("R14 irq", {31'b0, irq}, 32'h0);

    // R2: master control readback
    bus_write(A_MCTL, 32'h3);
    bus_read(A_MCTL, v); chk("R2", v, 32'h3);
    bus_write(A_MCTL, 32'hFFFF_FFFC);
    bus_read(A_MCTL, v); chk("R2", v, 32'h0);

    // R5: direct enable sweep
    for (int e = 0; e < 256; e++) begin
      bus_write(A_ENA, 32'(e));
      bus_read(A_ENA, v); chk("R5", v, 32'(e));
    end
    bus_write(A_ENA, 32'hFFFF_FF00);
    bus_read(A_ENA, v); chk("R5 upper", v, 32'h0);

    // R3 / R4: set and clear sweeps
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a8 = 8'(i * 17);
        logic [7:0] b8 = 8'(j * 13 + i);
        bus_write(A_ENA, {24'b0, a8});
        bus_write(A_SETE, {24'hFFFFFF, b8});
        bus_read(A_ENA, v); chk("R3", v, {24'b0, a8 | b8});
        bus_write(A_ENA, {24'b0, a8});
        bus_write(A_CLRE, {24'b0, b8});
        bus_read(A_ENA, v); chk("R4", v, {24'b0, a8 & ~b8});
      end
    end
    // R1: write-only ports read as zero
    bus_read(A_ACK, v);  chk("R1", v, 32'h0);
    bus_read(A_SETE, v); chk("R1", v, 32'h0);
    bus_read(A_CLRE, v); chk("R1", v, 32'h0);

    // R7 / R8: one-cycle pulse on all lines with latching on
    bus_write(A_MCTL, 32'h2);
    drive_src(8'hFF);
    drive_src(8'h00);
    bus_read(A_STAT, v); chk("R7 R8 pulse", v, 32'hFF);
    bus_write(A_ENA, 32'hFF);
    chk("R12 me off", {31'b0, irq}, 32'h0);

    // R10 / R11 / R12: pending, vector, output over every enable value
    bus_write(A_MCTL, 32'h3);
    for (int e = 0; e < 256; e++) begin
      bus_write(A_ENA, 32'(e));
      bus_read(A_PEND, v); chk("R10", v, 32'(e));
      bus_read(A_VEC, v);  chk("R11", v, lowest(8'(e)));
      chk("R12", {31'b0, irq}, {31'b0, (e != 0)});
    end

    // R6: read-only registers ignore writes
    bus_write(A_STAT, 32'h0);
    bus_write(A_PEND, 32'h0);
    bus_write(A_VEC, 32'h0);
    bus_read(A_STAT, v); chk("R6 ignore", v, 32'hFF);

    // R6: acknowledge clears selected bits
    bus_write(A_ACK, 32'h0F);
    bus_read(A_STAT, v); chk("R6 ack", v, 32'hF0);
    bus_write(A_ACK, 32'hFFFF_FFFF);
    bus_read(A_STAT, v); chk("R6 ack all", v, 32'h0);

    // R8: level line held high survives acknowledge
    drive_src(8'h01);
    bus_write(A_ACK, 32'h01);
    bus_read(A_STAT, v); chk("R8 hold", v, 32'h01);
    drive_src(8'h00);
    bus_write(A_ACK, 32'h01);
    bus_read(A_STAT, v); chk("R8 release", v, 32'h0);

    // R7: edge line held high does not re-latch
    drive_src(8'h10);
    bus_read(A_STAT, v); chk("R7 edge", v, 32'h10);
    bus_write(A_ACK, 32'h10);
    repeat (3) @(negedge clk);
    bus_read(A_STAT, v); chk("R7 held", v, 32'h0);
    drive_src(8'h00);

    // R13: rising edge and acknowledge on the same bit in one cycle
    drive_src(8'h20);
    drive_src(8'h00);
    bus_read(A_STAT, v); chk("R13 pre", v, 32'h20);
    @(negedge clk);
    src = 8'h20; wr = 1'b1; addr = A_ACK; wdata = 32'h20;
    @(negedge clk);
    wr = 1'b0; wdata = '0; src = 8'h00;
    bus_read(A_STAT, v); chk("R13", v, 32'h20);
    bus_write(A_ACK, 32'hFFFF_FFFF);

    // R9: latching disabled
    bus_write(A_MCTL, 32'h1);
    drive_src(8'hFF);
    drive_src(8'h00);
    bus_read(A_STAT, v); chk("R9", v, 32'h0);
    chk("R9 irq", {31'b0, irq}, 32'h0);
    bus_read(A_VEC, v);  chk("R11 none", v, 32'hFFFF_FFFF);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule